// File: doc/BRIEF.md
# Event Burst Pattern Checker

This block watches one stream of timestamped events and decides, event by event, whether the stream respects a burst discipline. Events are expected to arrive in bursts. Each burst may hold only a limited number of events and may last only a limited time. After each burst, a minimum event-free gap must pass before the next burst starts. Three runtime inputs set these limits. The timestamps carry the time, so the check does not depend on any sampling clock and the clock rate has no effect on the verdicts.

Each accepted event produces one verdict one clock later. A verdict is either a pass or a fail, and a fail carries a two-bit violation code. Any violation drops the checker back to idle, so the next event starts a fresh burst. Timestamps are assumed never to decrease, and the window arithmetic does not wrap.

Top module: `burst_pattern_checker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `vrd_valid` is low and the checker is idle.
- R2: An event that arrives while the checker is idle opens a burst. Its timestamp becomes the burst start and the burst count becomes 1. The event passes unless the count limit is zero.
- R3: Every event with `evt_valid` high gives exactly one verdict, with `vrd_valid` high in the next cycle. A cycle with no event gives no verdict in the next cycle.
- R4: Every event that falls in an open burst window adds one to the burst count. The event that takes the count above `cfg_max_count` fails with code 2'b01.
- R5: The window closes at burst start plus `cfg_max_len`, and the close is inclusive. An event stamped exactly at the close is counted in the burst.
- R6: An event stamped strictly after the window close and strictly before close plus `cfg_min_gap` fails with code 2'b10.
- R7: An event stamped at or after close plus `cfg_min_gap` opens a new burst. Its count restarts at 1 and its start is its own timestamp.
- R8: After any fail the checker is idle, so the next event opens a fresh burst whatever its timestamp.
- R9: A pass verdict carries code 2'b00. A fail verdict carries 2'b01 or 2'b10.
- R10: The limits are read when each event is accepted. With `cfg_max_count` at zero, every event fails with code 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_time | input | TW | Timestamp of the event |
| cfg_max_count | input | CW | Largest number of events allowed in one burst |
| cfg_max_len | input | TW | Longest burst duration, in timestamp units |
| cfg_min_gap | input | TW | Shortest event-free time after a burst window |
| vrd_valid | output | 1 | A verdict is presented this cycle |
| vrd_pass | output | 1 | 1 for a pass, 0 for a fail |
| vrd_code | output | 2 | Violation code: 00 none, 01 too many events, 10 event in the quiet gap |

## Verification
The bound checker watches, on every cycle:
- that each event produces exactly one verdict one cycle later;
- that the verdict code agrees with the pass flag;
- that an event classified as falling in the quiet gap gives a code 2'b10 fail;
- that an idle event opens a burst and passes;
- that the state after any fail is idle.

Only the bench scenarios can confirm the timestamp boundaries:
- an event exactly at the window close;
- an event one unit before the end of the gap;
- an event exactly at the end of the gap;
- the count rolling over into a new burst;
- the runtime change of limits, including a zero count limit.

// File: rtl/burst_chk_pkg.sv
package burst_chk_pkg;

  typedef enum logic [1:0] {
    VC_NONE      = 2'b00,
    VC_OVERCOUNT = 2'b01,
    VC_QUIET     = 2'b10
  } viol_code_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_OPEN = 1'b1
  } burst_phase_e;

endpackage

// File: rtl/bpc_event_classify.sv
module bpc_event_classify
  import burst_chk_pkg::*;
#(
  parameter int TW = 32,
  parameter int CW = 8
) (
  input  burst_phase_e   phase,
  input  logic [TW-1:0]  burst_start,
  input  logic [CW-1:0]  burst_count,
  input  logic [TW-1:0]  evt_time,
  input  logic [CW-1:0]  cfg_max_count,
  input  logic [TW-1:0]  cfg_max_len,
  input  logic [TW-1:0]  cfg_min_gap,
  output logic           ev_opens,
  output logic           ev_in_window,
  output logic           ev_in_quiet,
  output logic           ev_overcount,
  output logic [CW-1:0]  next_count,
  output viol_code_e     ev_code
);

  localparam int CLW = TW + 1;
  localparam int QEW = TW + 2;
  localparam int NCW = CW + 1;

  // Window close: start plus largest burst length (inclusive bound).
  function automatic logic [CLW-1:0] window_close(input logic [TW-1:0] start,
                                                  input logic [TW-1:0] len);
    return {1'b0, start} + {1'b0, len};
  endfunction

  // End of the quiet period: window close plus the shortest gap.
  function automatic logic [QEW-1:0] quiet_end(input logic [CLW-1:0] close,
                                               input logic [TW-1:0] gap);
    return {1'b0, close} + {2'b00, gap};
  endfunction

  logic [CLW-1:0] close_t;
  logic [QEW-1:0] qend_t;
  logic [QEW-1:0] t_ext;
  logic [NCW-1:0] cnt_sum;
  logic           after_close;
  logic           before_qend;

  always_comb begin
    close_t     = window_close(burst_start, cfg_max_len);
    qend_t      = quiet_end(close_t, cfg_min_gap);
    t_ext       = {2'b00, evt_time};
    after_close = t_ext > {1'b0, close_t};
    before_qend = t_ext < qend_t;

    ev_in_window = (phase == PH_OPEN) && !after_close;
    ev_in_quiet  = (phase == PH_OPEN) && after_close && before_qend;
    ev_opens     = (phase == PH_IDLE) || (after_close && !before_qend);

    cnt_sum      = ev_in_window ? ({1'b0, burst_count} + NCW'(1)) : NCW'(1);
    ev_overcount = !ev_in_quiet && (cnt_sum > {1'b0, cfg_max_count});
    next_count   = cnt_sum[CW-1:0];

    if (ev_in_quiet)       ev_code = VC_QUIET;
    else if (ev_overcount) ev_code = VC_OVERCOUNT;
    else                   ev_code = VC_NONE;
  end

endmodule

// File: rtl/bpc_burst_state.sv
module bpc_burst_state
  import burst_chk_pkg::*;
#(
  parameter int TW = 32,
  parameter int CW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt_valid,
  input  logic           ev_fail,
  input  logic           ev_opens,
  input  logic [TW-1:0]  evt_time,
  input  logic [CW-1:0]  next_count,
  output burst_phase_e   phase,
  output logic [TW-1:0]  burst_start,
  output logic [CW-1:0]  burst_count
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      burst_start <= '0;
      burst_count <= '0;
    end else if (evt_valid) begin
      if (ev_fail) begin
        phase       <= PH_IDLE;
        burst_count <= '0;
      end else begin
        phase       <= PH_OPEN;
        burst_count <= next_count;
        if (ev_opens) burst_start <= evt_time;
      end
    end
  end

endmodule

// File: rtl/bpc_verdict_reg.sv
module bpc_verdict_reg
  import burst_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_valid,
  input  viol_code_e ev_code,
  output logic       vrd_valid,
  output logic       vrd_pass,
  output logic [1:0] vrd_code
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vrd_valid <= 1'b0;
      vrd_pass  <= 1'b0;
      vrd_code  <= 2'b00;
    end else begin
      vrd_valid <= evt_valid;
      vrd_pass  <= evt_valid && (ev_code == VC_NONE);
      vrd_code  <= evt_valid ? ev_code : 2'b00;
    end
  end

endmodule

// File: rtl/burst_pattern_checker.sv
module burst_pattern_checker
  import burst_chk_pkg::*;
#(
  parameter int TW = 32,
  parameter int CW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt_valid,
  input  logic [TW-1:0]  evt_time,
  input  logic [CW-1:0]  cfg_max_count,
  input  logic [TW-1:0]  cfg_max_len,
  input  logic [TW-1:0]  cfg_min_gap,
  output logic           vrd_valid,
  output logic           vrd_pass,
  output logic [1:0]     vrd_code
);

  burst_phase_e   phase;
  logic [TW-1:0]  burst_start;
  logic [CW-1:0]  burst_count;
  logic           ev_opens;
  logic           ev_in_window;
  logic           ev_in_quiet;
  logic           ev_overcount;
  logic           ev_fail;
  logic           burst_open;
  logic [CW-1:0]  next_count;
  viol_code_e     ev_code;

  assign ev_fail    = (ev_code != VC_NONE);
  assign burst_open = (phase == PH_OPEN);

  bpc_event_classify #(.TW(TW), .CW(CW)) u_classify (
    .phase         (phase),
    .burst_start   (burst_start),
    .burst_count   (burst_count),
    .evt_time      (evt_time),
    .cfg_max_count (cfg_max_count),
    .cfg_max_len   (cfg_max_len),
    .cfg_min_gap   (cfg_min_gap),
    .ev_opens      (ev_opens),
    .ev_in_window  (ev_in_window),
    .ev_in_quiet   (ev_in_quiet),
    .ev_overcount  (ev_overcount),
    .next_count    (next_count),
    .ev_code       (ev_code)
  );

  bpc_burst_state #(.TW(TW), .CW(CW)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .ev_fail     (ev_fail),
    .ev_opens    (ev_opens),
    .evt_time    (evt_time),
    .next_count  (next_count),
    .phase       (phase),
    .burst_start (burst_start),
    .burst_count (burst_count)
  );

  bpc_verdict_reg u_verdict (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .ev_code   (ev_code),
    .vrd_valid (vrd_valid),
    .vrd_pass  (vrd_pass),
    .vrd_code  (vrd_code)
  );

endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_valid,
  input logic [CW-1:0] cfg_max_count,
  input logic          vrd_valid,
  input logic          vrd_pass,
  input logic [1:0]    vrd_code,
  input logic          burst_open,
  input logic          ev_in_quiet,
  input logic          ev_in_window
);

  AST_VERDICT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> vrd_valid);  // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> !vrd_valid);  // R3
  AST_PASS_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_valid && vrd_pass) |-> (vrd_code == 2'b00));  // R9
  AST_FAIL_CODE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_valid && !vrd_pass) |-> (vrd_code == 2'b01 || vrd_code == 2'b10));  // R9
  AST_QUIET_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && ev_in_quiet) |=> (!vrd_pass && vrd_code == 2'b10));  // R6
  AST_IDLE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !burst_open && cfg_max_count != '0) |=> (vrd_pass && burst_open));  // R2
  AST_FAIL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_valid && !vrd_pass) |-> !burst_open);  // R8
  AST_WINDOW_NOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_in_window && ev_in_quiet));  // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> (!vrd_valid && !burst_open));  // R1

endmodule

bind burst_pattern_checker bpc_checker #(.CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .evt_valid     (evt_valid),
  .cfg_max_count (cfg_max_count),
  .vrd_valid     (vrd_valid),
  .vrd_pass      (vrd_pass),
  .vrd_code      (vrd_code),
  .burst_open    (burst_open),
  .ev_in_quiet   (ev_in_quiet),
  .ev_in_window  (ev_in_window)
);

// File: tb/sim_burst_pattern_checker.sv
module sim_burst_pattern_checker;

  localparam int TW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evt_valid = 1'b0;
  logic [TW-1:0] evt_time = '0;
  logic [CW-1:0] cfg_max_count = 8'd3;
  logic [TW-1:0] cfg_max_len = 32'd10;
  logic [TW-1:0] cfg_min_gap = 32'd20;
  logic          vrd_valid;
  logic          vrd_pass;
  logic [1:0]    vrd_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Expected item: {pass, code}, plus the requirement it demonstrates.
  logic [2:0] exp_q[$];
  string      tag_q[$];

  // Independent reference state.
  bit          m_open = 1'b0;
  longint      m_start = 0;
  int          m_cnt = 0;

  always #2 clk = ~clk;  // 250 MHz

  burst_pattern_checker #(.TW(TW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_time(evt_time),
    .cfg_max_count(cfg_max_count), .cfg_max_len(cfg_max_len),
    .cfg_min_gap(cfg_min_gap), .vrd_valid(vrd_valid), .vrd_pass(vrd_pass),
    .vrd_code(vrd_code)
  );

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Driver: predicts the verdict from the requirements, pushes it, drives the event.
  task automatic send(input longint t, input string req);
    longint close_t, qend_t;
    bit     fresh;
    bit     ok;
    logic [1:0] code;
    close_t = m_start + longint'(cfg_max_len);
    qend_t  = close_t + longint'(cfg_min_gap);
    code    = 2'b00;
    if (!m_open) fresh = 1'b1;
    else if (t <= close_t) fresh = 1'b0;
    else if (t < qend_t) begin fresh = 1'b0; code = 2'b10; end
    else fresh = 1'b1;
    if (code == 2'b00) begin
      if (fresh) begin m_cnt = 1; m_start = t; end
      else m_cnt = m_cnt + 1;
      if (m_cnt > int'(cfg_max_count)) code = 2'b01;
    end
    ok = (code == 2'b00);
    if (ok) m_open = 1'b1;
    else begin m_open = 1'b0; m_cnt = 0; end
    exp_q.push_back({ok, code});
    tag_q.push_back(req);
    evt_valid = 1'b1;
    evt_time  = TW'(t);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  // Monitor: pops and compares each verdict as it appears.
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (vrd_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", $sformatf("actual unexpected verdict expected none"));
        end else begin
          logic [2:0] e;
          string r;
          e = exp_q.pop_front();
          r = tag_q.pop_front();
          check({vrd_pass, vrd_code} == e, r,
                $sformatf("actual pass=%0b code=%b expected pass=%0b code=%b",
                          vrd_pass, vrd_code, e[2], e[1:0]));
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(vrd_valid == 1'b0, "R1", $sformatf("actual vrd_valid=%0b expected 0", vrd_valid));
    rst_n = 1'b1;
    @(negedge clk);
    check(vrd_valid == 1'b0, "R1", $sformatf("actual vrd_valid=%0b expected 0", vrd_valid));

    // limits: count 3, length 10, gap 20
    send(100, "R2");           // opens burst, close 110, quiet end 130
    send(105, "R4");
    send(110, "R5");           // exactly at close: counted (3rd)
    send(115, "R6");           // quiet gap -> 10
    send(116, "R8");           // fresh burst after fail, close 126
    send(117, "R4");
    send(118, "R4");
    send(119, "R4");           // 4th -> 01
    @(negedge clk); @(negedge clk);   // idle cycles, no verdicts (R3)
    send(200, "R2");           // close 210, quiet end 230
    send(229, "R6");           // one before quiet end -> 10
    send(300, "R8");           // close 310, quiet end 330
    send(330, "R7");           // exactly at quiet end -> new burst
    send(335, "R7");
    send(340, "R7");           // 3rd of new burst, close 340
    send(340, "R4");           // 4th in new burst -> 01
    // runtime limit change, zero count limit
    cfg_max_count = 8'd0;
    send(500, "R10");
    send(501, "R10");
    cfg_max_count = 8'd2;
    cfg_min_gap   = 32'd0;
    send(600, "R10");          // close 610, no gap
    send(611, "R7");           // past close with zero gap -> new burst
    send(621, "R5");           // exactly at new close 621
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3",
          $sformatf("actual %0d pending expected 0", exp_q.size()));
    done = 1'b1;
  end

  initial begin : watchdog
    int n;
    for (n = 0; n < 20000 && !done; n++) @(negedge clk);
    if (!done) check(1'b0, "R3", "actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule